// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block runs in the master-clock domain of an audio converter. It watches the sample-rate frame clock and counts how many master clocks fit into one sample period. It then matches that count against the six oversampling ratios the converter supports. No configuration is needed: the ratio is found from the signals alone.

From the matched ratio the block picks the oversampling rate of the converter path. It also keeps the path muted until the measurement is stable. It drops back to mute as soon as a period falls outside tolerance or the frame clock goes missing.

A second, free-running slow reference clock drives a watchdog that requests power-down when the master clock stops. The block stays idle until the enable input has been seen going from low to high.

Top module: `mclk_ratio_detect`

## Requirements
- R1: Ratio codes are 0, 1, 2, 3, 4 and 5 for 128, 192, 256, 384, 512 and 768 master clocks per sample period. While locked, `ratio_code` shows the code of the locked ratio. While unlocked, it reads 0.
- R2: The period P is the number of master-clock cycles between two consecutive rising edges of `frame_clk`. P matches a ratio when |P − ratio| ≤ 8. A P that is 9 or more away from every ratio is rejected. Jitter that stays within ±8 does not disturb lock.
- R3: `locked` rises only after two consecutive periods match the same ratio, that is at the third rising frame edge after arming. It rises within four master clocks of that edge. The code stays stable while lock holds.
- R4: Lock is lost on the first period that is rejected or that matches a different ratio. Lock is also lost when 777 master clocks pass with no rising frame edge.
- R5: `mute` is high exactly when `locked` is low.
- R6: `hi_rate` (64x oversampling) is high when locked to 128 or 192. It is low for the other ratios (128x oversampling) and while unlocked.
- R7: While `enable` is low, the block is unlocked and muted, and frame edges have no effect. Measurement starts only after `enable` goes from low to high. If `enable` is already high when reset ends, the block stays idle until such a transition.
- R8: When the master clock stops, `pwr_down` rises after about `STOP_LIMIT` reference-clock cycles. It falls again within a few reference cycles once the master clock runs.
- R9: After reset, `locked`=0, `mute`=1, `hi_rate`=0, `ratio_code`=0 and `pwr_down`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset, master-clock domain |
| ref_clk | input | 1 | Free-running slow reference clock for the stop watchdog |
| ref_rst | input | 1 | Synchronous active-high reset, reference domain |
| frame_clk | input | 1 | Sample-rate frame clock, asynchronous to `mclk` |
| enable | input | 1 | Operation enable, synchronous to `mclk` |
| ratio_code | output | 3 | Locked ratio code (R1), 0 when unlocked |
| locked | output | 1 | Ratio measurement is stable |
| mute | output | 1 | Converter path muted and shut down |
| hi_rate | output | 1 | 1 = 64x oversampling, 0 = 128x |
| pwr_down | output | 1 | Master clock stopped, power-down request |

## Verification
The hardest situation to reach from the ports is a master clock that truly stops while the reference clock keeps running. The bench reaches it by gating its own master-clock generator at a low phase. It holds the clock there for several microseconds, then releases it and watches the request clear. The tolerance edges are also hard to hit, because a period must land exactly 8 or 9 clocks from a ratio. The stimulus produces frame edges a chosen whole number of master clocks apart, so it can hit each edge exactly, and it adds a silent stretch longer than 776 clocks. A behavioural model tracks the expected lock, code and rate select on every master clock.

// File: rtl/mrd_pkg.sv
`timescale 1ns/1ps
package mrd_pkg;
    localparam int NUM_RATIOS = 6;
    localparam int CODE_W     = 3;
    localparam int TOL        = 8;
    localparam int BASE_RATIO = 128;
    localparam int MAX_RATIO  = 768;
    localparam int MAX_WAIT   = MAX_RATIO + TOL;
    localparam int CNT_W      = $clog2(MAX_WAIT + 2);

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        logic  hit;
        code_t code;
    } verdict_t;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_WAIT,
        ST_SEEK,
        ST_CAND,
        ST_LOCK
    } lock_st_t;

    // even codes are powers of two times the base, odd codes add one half
    function automatic int ratio_of(int idx);
        int base;
        base = BASE_RATIO << (idx >> 1);
        return ((idx % 2) == 1) ? base + base / 2 : base;
    endfunction

    function automatic verdict_t classify(cnt_t period);
        verdict_t v;
        int       d;
        v = '0;
        for (int i = 0; i < NUM_RATIOS; i++) begin
            d = int'(period) - ratio_of(i);
            if (d <= TOL && d >= -TOL) begin
                v.hit  = 1'b1;
                v.code = code_t'(i);
            end
        end
        return v;
    endfunction

    function automatic logic uses_half_osr(code_t c);
        return c < code_t'(2);
    endfunction
endpackage

// File: rtl/mrd_edge_sync.sv
`timescale 1ns/1ps
module mrd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], din};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/mrd_period_fsm.sv
`timescale 1ns/1ps
module mrd_period_fsm
    import mrd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  enable,
    input  logic  rise,
    output logic  locked,
    output code_t code
);
    localparam cnt_t MAXC = cnt_t'(MAX_WAIT);

    lock_st_t st;
    cnt_t     cnt;
    code_t    cand;
    logic     en_q;
    verdict_t vd;

    assign vd = classify(cnt + 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_OFF;
            cnt  <= '0;
            cand <= '0;
            en_q <= 1'b1;
        end else begin
            en_q <= enable;
            if (!enable) begin
                st  <= ST_OFF;
                cnt <= '0;
            end else if (st == ST_OFF) begin
                cnt <= '0;
                if (!en_q) st <= ST_WAIT;
            end else begin
                if (rise)             cnt <= '0;
                else if (cnt != MAXC) cnt <= cnt + 1'b1;
                if (rise) begin
                    if (st == ST_WAIT || !vd.hit) begin
                        st <= ST_SEEK;
                    end else if ((st == ST_CAND || st == ST_LOCK) && vd.code == cand) begin
                        st <= ST_LOCK;
                    end else begin
                        st   <= ST_CAND;
                        cand <= vd.code;
                    end
                end else if (st != ST_WAIT && cnt == MAXC) begin
                    st <= ST_SEEK;
                end
            end
        end
    end

    assign locked = (st == ST_LOCK);
    assign code   = cand;

    assert_lock_on_edge_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(st == ST_LOCK) |-> $past(rise));

    assert_code_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LOCK && $past(st == ST_LOCK)) |-> $stable(cand));

    assert_timeout_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (enable && !rise && cnt == MAXC && st != ST_WAIT) |=> (st != ST_LOCK));

    assert_idle_when_off_R7: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (st == ST_OFF));
endmodule

// File: rtl/mrd_clock_watch.sv
`timescale 1ns/1ps
module mrd_clock_watch #(
    parameter int LIMIT = 8
) (
    input  logic mclk,
    input  logic mrst,
    input  logic ref_clk,
    input  logic ref_rst,
    output logic pwr_down
);
    localparam int LW = $clog2(LIMIT + 1);
    localparam logic [LW-1:0] LIM = LW'(LIMIT);

    logic          req;
    logic [1:0]    echo;
    logic [1:0]    ack_s;
    logic [LW-1:0] cnt;
    logic          match;

    // master-clock side returns the request level
    always_ff @(posedge mclk) begin
        if (mrst) echo <= '0;
        else      echo <= {echo[0], req};
    end

    assign match = (ack_s[1] == req);

    always_ff @(posedge ref_clk) begin
        if (ref_rst) begin
            ack_s    <= '0;
            req      <= 1'b0;
            cnt      <= '0;
            pwr_down <= 1'b0;
        end else begin
            ack_s <= {ack_s[0], echo[1]};
            if (match) begin
                req <= ~req;
                cnt <= '0;
            end else if (cnt != LIM) begin
                cnt <= cnt + 1'b1;
            end
            pwr_down <= (cnt == LIM);
        end
    end

    assert_pd_clears_on_echo_R8: assert property (@(posedge ref_clk) disable iff (ref_rst)
        match |-> ##2 !pwr_down);
endmodule

// File: rtl/mclk_ratio_detect.sv
`timescale 1ns/1ps
module mclk_ratio_detect
    import mrd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STOP_LIMIT  = 8
) (
    input  logic              mclk,
    input  logic              rst,
    input  logic              ref_clk,
    input  logic              ref_rst,
    input  logic              frame_clk,
    input  logic              enable,
    output logic [CODE_W-1:0] ratio_code,
    output logic              locked,
    output logic              mute,
    output logic              hi_rate,
    output logic              pwr_down
);
    logic  rise;
    logic  lk;
    code_t cd;

    mrd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (mclk),
        .rst (rst),
        .din (frame_clk),
        .rise(rise)
    );

    mrd_period_fsm u_fsm (
        .clk   (mclk),
        .rst   (rst),
        .enable(enable),
        .rise  (rise),
        .locked(lk),
        .code  (cd)
    );

    mrd_clock_watch #(.LIMIT(STOP_LIMIT)) u_watch (
        .mclk    (mclk),
        .mrst    (rst),
        .ref_clk (ref_clk),
        .ref_rst (ref_rst),
        .pwr_down(pwr_down)
    );

    assign locked     = lk;
    assign mute       = ~lk;
    assign ratio_code = lk ? cd : '0;
    assign hi_rate    = lk & uses_half_osr(cd);
endmodule

// File: tb/tb_mclk_ratio_detect.sv
`timescale 1ns/1ps
module tb_mclk_ratio_detect;
    localparam int MAXC = 776;

    logic clk = 1'b0, ref_clk = 1'b0;
    logic rst = 1'b1, ref_rst = 1'b1;
    logic frame = 1'b0, enable = 1'b1;
    logic mclk_run = 1'b1;
    logic [2:0] ratio_code;
    logic locked, mute, hi_rate, pwr_down;

    int n_checks = 0, n_fail = 0;
    bit check_on = 1'b0;

    // behavioural reference state
    bit h[3];
    bit m_en_q, m_armed, m_start, m_cand_ok, m_locked;
    int m_cand, m_cnt;
    int ratios[6] = '{128, 192, 256, 384, 512, 768};

    mclk_ratio_detect #(.STOP_LIMIT(8)) dut (
        .mclk(clk), .rst(rst), .ref_clk(ref_clk), .ref_rst(ref_rst),
        .frame_clk(frame), .enable(enable), .ratio_code(ratio_code),
        .locked(locked), .mute(mute), .hi_rate(hi_rate), .pwr_down(pwr_down)
    );

    initial forever begin #2.5; if (mclk_run) clk = ~clk; end
    initial forever #50 ref_clk = ~ref_clk;

    function automatic int model_class(int per);
        int k = -1;
        for (int i = 0; i < 6; i++)
            if (per - ratios[i] <= 8 && ratios[i] - per <= 8) k = i;
        return k;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        m_start = 0; m_cand_ok = 0; m_locked = 0; m_cnt = 0;
    endtask

    always @(posedge clk) begin
        bit r;
        int per;
        int k;
        r = h[1] && !h[0];
        if (rst) begin
            h[0] = 0; h[1] = 0; h[2] = 0;
            m_en_q = 1; m_armed = 0; m_cand = 0;
            model_clear();
        end else begin
            h[0] = h[1]; h[1] = h[2]; h[2] = frame;
            if (!enable) begin
                m_armed = 0;
                model_clear();
            end else if (!m_armed) begin
                if (!m_en_q) m_armed = 1;
                model_clear();
            end else if (r) begin
                if (m_start) begin
                    per = m_cnt + 1;
                    k = model_class(per);
                    if (k < 0) begin
                        m_locked = 0; m_cand_ok = 0;
                    end else if (m_cand_ok && k == m_cand) begin
                        m_locked = 1;
                    end else begin
                        m_cand = k; m_cand_ok = 1; m_locked = 0;
                    end
                end
                m_start = 1;
                m_cnt = 0;
            end else begin
                if (m_start && m_cnt >= MAXC) begin
                    m_locked = 0; m_cand_ok = 0;
                end
                if (m_cnt < MAXC) m_cnt++;
            end
            m_en_q = enable;
        end
    end

    always @(negedge clk) begin
        int ec;
        bit eh;
        if (check_on) begin
            ec = m_locked ? m_cand : 0;
            eh = m_locked && ratios[m_cand] <= 192;
            check(locked == m_locked, "R3 lock vs model", int'(locked), int'(m_locked));
            check(mute == !m_locked, "R5 mute vs model", int'(mute), int'(!m_locked));
            check(int'(ratio_code) == ec, "R1 code vs model", int'(ratio_code), ec);
            check(hi_rate == eh, "R6 rate select vs model", int'(hi_rate), int'(eh));
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frames(input int per, input int n);
        for (int i = 0; i < n; i++) begin
            frame = 1'b1;
            cycles(per / 2);
            frame = 1'b0;
            cycles(per - per / 2);
        end
    endtask

    task automatic expect_lock(input int code, input string tag);
        check(locked == 1'b1, tag, int'(locked), 1);
        check(int'(ratio_code) == code, tag, int'(ratio_code), code);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #900000;
        n_checks++;
        n_fail++;
        $display("FAIL R9 watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        cycles(2);
        check_on = 1'b1;
        cycles(60);
        rst = 1'b0;
        ref_rst = 1'b0;
        cycles(200);
        // R9 reset state
        check(locked == 1'b0, "R9 locked after reset", int'(locked), 0);
        check(mute == 1'b1, "R9 mute after reset", int'(mute), 1);
        check(hi_rate == 1'b0, "R9 hi_rate after reset", int'(hi_rate), 0);
        check(ratio_code == 3'd0, "R9 code after reset", int'(ratio_code), 0);
        check(pwr_down == 1'b0, "R9 pwr_down after reset", int'(pwr_down), 0);

        // R7 enable high out of reset never arms
        frames(256, 4);
        check(locked == 1'b0, "R7 no arm without enable rise", int'(locked), 0);

        enable = 1'b0;
        cycles(4);
        enable = 1'b1;
        cycles(2);
        frames(256, 2);
        check(locked == 1'b0, "R3 not locked after one period", int'(locked), 0);
        frames(256, 1);
        expect_lock(2, "R3 lock at third edge 256");
        check(hi_rate == 1'b0, "R6 256 uses 128x", int'(hi_rate), 0);
        check(mute == 1'b0, "R5 unmuted when locked", int'(mute), 0);

        // R1 sweep of ratios
        frames(128, 3);
        expect_lock(0, "R1 ratio 128");
        check(hi_rate == 1'b1, "R6 128 uses 64x", int'(hi_rate), 1);
        frames(192, 3);
        expect_lock(1, "R1 ratio 192");
        check(hi_rate == 1'b1, "R6 192 uses 64x", int'(hi_rate), 1);
        frames(384, 3);
        expect_lock(3, "R1 ratio 384");
        frames(512, 3);
        expect_lock(4, "R1 ratio 512");
        frames(768, 3);
        expect_lock(5, "R1 ratio 768");
        check(hi_rate == 1'b0, "R6 768 uses 128x", int'(hi_rate), 0);

        // R2 tolerance boundaries
        frames(264, 3);
        expect_lock(2, "R2 +8 accepted");
        frames(248, 3);
        expect_lock(2, "R2 -8 accepted");
        frames(265, 2);
        check(locked == 1'b0, "R2 +9 rejected", int'(locked), 0);
        frames(247, 3);
        check(locked == 1'b0, "R2 -9 rejected", int'(locked), 0);
        frames(256, 3);
        for (int i = 0; i < 3; i++) begin
            frames(261, 1);
            frames(250, 1);
        end
        expect_lock(2, "R2 jitter within tolerance");

        // R4 change of ratio and missing frame
        frames(384, 2);
        check(locked == 1'b0, "R4 changed ratio drops lock", int'(locked), 0);
        frames(384, 1);
        expect_lock(3, "R4 relock on new ratio");
        frame = 1'b0;
        cycles(800);
        check(locked == 1'b0, "R4 missing frame drops lock", int'(locked), 0);

        // R7 enable low mid-lock
        frames(512, 3);
        expect_lock(4, "R7 lock before disable");
        enable = 1'b0;
        cycles(3);
        check(locked == 1'b0, "R7 disable unlocks", int'(locked), 0);
        check(mute == 1'b1, "R7 disable mutes", int'(mute), 1);
        frames(512, 3);
        check(locked == 1'b0, "R7 frames ignored while disabled", int'(locked), 0);
        enable = 1'b1;
        frames(512, 3);
        expect_lock(4, "R7 relock after enable rise");

        // R8 stopped master clock
        check(pwr_down == 1'b0, "R8 no request while running", int'(pwr_down), 0);
        mclk_run = 1'b0;
        #3000;
        check(pwr_down == 1'b1, "R8 request after clock stops", int'(pwr_down), 1);
        mclk_run = 1'b1;
        #1500;
        check(pwr_down == 1'b0, "R8 request clears on restart", int'(pwr_down), 0);
        cycles(4);
        finish_run();
    end
endmodule